// File: doc/BRIEF.md
# Timer Output Compare Unit

This block watches a timer count and compares it with a programmable compare value. When the two are equal on a timer tick, it raises a sticky match flag and updates a one-bit waveform state. A 2-bit action mode chooses the update: hold, toggle, clear or set. A CPU side writes the count, the compare value and the mode. It can also fire a force strobe, which applies the mode's action without a real match.

A CPU write to the count arms a one-shot suppression register. The next timer tick then produces no match, however many idle cycles pass before that tick arrives. Software can therefore load the count with the compare value without a spurious event. The output pin takes the waveform state whenever the mode is nonzero and the general port bit otherwise. The pin is driven only when the direction bit is set. A simple up-counter is included so the unit can be used on its own.

Top module: `tmr_ocmp_unit`

## Requirements
- R1: After reset the count, compare value, mode, match flag and waveform state are all 0.
- R2: Each cycle with `tick` high increments the count by one, wrapping from all-ones to 0. A counter write loads `cnt_wdata` and wins over a tick in the same cycle.
- R3: A real match occurs in a cycle with `tick` high, no counter write, no pending block and count equal to compare value. One cycle later the flag is 1 and the mode's action has been applied.
- R4: Mode encoding on a match or force: 2'b00 leaves the state unchanged, 2'b01 inverts it, 2'b10 makes it 0, and 2'b11 makes it 1.
- R5: A high `force_stb` applies the current mode's action to the waveform state. It does not set the flag and does not change the count.
- R6: After a counter write, the first following tick produces no match, even if idle cycles come between. A write of the compare value itself therefore leaves both the flag and the state unchanged.
- R7: Once that tick has passed, later ticks match normally again.
- R8: The flag stays at 1 until a cycle with `flag_clr` high clears it. A match in the same cycle as the clear leaves the flag at 1.
- R9: The mode is not buffered. A mode written in one cycle governs any match or force from the next cycle on.
- R10: `pin_out` equals the waveform state when the mode is nonzero and `port_val` when the mode is 2'b00. `pin_oe` equals `dir`.
- R11: The waveform state keeps its value when the mode changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Timer clock enable |
| cnt_wr | input | 1 | CPU write of the count |
| cnt_wdata | input | CNT_W | Count write data |
| cmp_wr | input | 1 | CPU write of the compare value |
| cmp_wdata | input | CNT_W | Compare write data |
| mode_wr | input | 1 | CPU write of the action mode |
| mode_wdata | input | 2 | Action mode write data |
| force_stb | input | 1 | Force strobe, one cycle |
| flag_clr | input | 1 | Write-one clear of the match flag |
| dir | input | 1 | Pin direction, 1 = drive |
| port_val | input | 1 | General port register bit |
| cnt_q | output | CNT_W | Current count |
| cmp_q | output | CNT_W | Current compare value |
| mode_q | output | 2 | Current action mode |
| match_flag | output | 1 | Sticky compare-match flag |
| oc_state | output | 1 | Waveform state register |
| pin_out | output | 1 | Pin value |
| pin_oe | output | 1 | Pin output enable |

## Verification
The hardest case to reach is a pending block that outlives several idle cycles. It shows only when a counter write of the compare value is followed by cycles without a tick and then a single tick that must stay silent. The stimulus loads the compare value into the count, holds `tick` low for a few cycles, then ticks once. It checks that neither the flag nor the state changes. It then rewinds the count and ticks up to the compare value to show that matching has resumed. A match and a flag clear are also made to coincide, and a force is issued under each mode.

// File: rtl/tmr_ocmp_pkg.sv
package tmr_ocmp_pkg;
   typedef enum logic [1:0] {
      OCM_HOLD   = 2'b00,
      OCM_TOGGLE = 2'b01,
      OCM_CLEAR  = 2'b10,
      OCM_SET    = 2'b11
   } ocm_mode_e;
endpackage

// File: rtl/tmr_ocmp_counter.sv
module tmr_ocmp_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cnt_q
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("tmr_ocmp_counter: CNT_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (wr_en) cnt_q <= wr_data;
      else if (tick)  cnt_q <= cnt_q + ONE;
   end

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (cnt_q == $past(wr_data)));
   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_en) |=> (cnt_q == $past(cnt_q) + ONE));
endmodule

// File: rtl/tmr_ocmp_match.sv
module tmr_ocmp_match #(
   parameter int CNT_W    = 8,
   parameter bit SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             flag_clr,
   output logic             hit,
   output logic             flag_q
);
   logic blk_q;
   logic equal;

   assign equal = (cnt_val == cmp_val);
   assign hit   = tick && !cnt_wr && !blk_q && equal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      blk_q <= 1'b0;
      else if (cnt_wr) blk_q <= 1'b1;
      else if (tick)   blk_q <= 1'b0;
   end

   generate
      if (SET_WINS) begin : g_set_wins
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flag_q <= 1'b0;
            else if (hit)      flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
         end
      end else begin : g_clr_wins
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flag_q <= 1'b0;
            else if (flag_clr) flag_q <= 1'b0;
            else if (hit)      flag_q <= 1'b1;
         end
      end
   endgenerate

   assert_flag_needs_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q && !hit) |=> !flag_q);
   assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !flag_clr) |=> flag_q);
   assert_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr) |=> !blk_q);
endmodule

// File: rtl/tmr_ocmp_wave.sv
module tmr_ocmp_wave
   import tmr_ocmp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hit,
   input  logic       force_stb,
   input  logic [1:0] mode,
   input  logic       dir,
   input  logic       port_val,
   output logic       oc_q,
   output logic       pin_out,
   output logic       pin_oe
);
   logic act;
   logic oc_nxt;

   assign act = hit || force_stb;

   always_comb begin
      oc_nxt = oc_q;
      if (act) begin
         case (ocm_mode_e'(mode))
            OCM_TOGGLE: oc_nxt = !oc_q;
            OCM_CLEAR:  oc_nxt = 1'b0;
            OCM_SET:    oc_nxt = 1'b1;
            default:    oc_nxt = oc_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oc_q <= 1'b0;
      else        oc_q <= oc_nxt;
   end

   assign pin_out = (mode != 2'b00) ? oc_q : port_val;
   assign pin_oe  = dir;

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !act |=> $stable(oc_q));
   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (act && mode == 2'b10) |=> !oc_q);
   assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (act && mode == 2'b11) |=> oc_q);
   assert_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (act && mode == 2'b01) |=> (oc_q != $past(oc_q)));
endmodule

// File: rtl/tmr_ocmp_unit.sv
module tmr_ocmp_unit #(
   parameter int CNT_W    = 8,
   parameter bit SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             cmp_wr,
   input  logic [CNT_W-1:0] cmp_wdata,
   input  logic             mode_wr,
   input  logic [1:0]       mode_wdata,
   input  logic             force_stb,
   input  logic             flag_clr,
   input  logic             dir,
   input  logic             port_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cmp_q,
   output logic [1:0]       mode_q,
   output logic             match_flag,
   output logic             oc_state,
   output logic             pin_out,
   output logic             pin_oe
);
   logic hit_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q  <= '0;
         mode_q <= 2'b00;
      end else begin
         if (cmp_wr)  cmp_q  <= cmp_wdata;
         if (mode_wr) mode_q <= mode_wdata;
      end
   end

   tmr_ocmp_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(cnt_wr),
      .wr_data(cnt_wdata), .cnt_q(cnt_q)
   );

   tmr_ocmp_match #(.CNT_W(CNT_W), .SET_WINS(SET_WINS)) u_match (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr),
      .cnt_val(cnt_q), .cmp_val(cmp_q), .flag_clr(flag_clr),
      .hit(hit_w), .flag_q(match_flag)
   );

   tmr_ocmp_wave u_wave (
      .clk(clk), .rst_n(rst_n), .hit(hit_w), .force_stb(force_stb),
      .mode(mode_q), .dir(dir), .port_val(port_val),
      .oc_q(oc_state), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   assert_block_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> !hit_w);
   assert_force_keeps_cnt_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (force_stb && !tick && !cnt_wr) |=> $stable(cnt_q));
   assert_force_no_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (force_stb && !hit_w && !match_flag) |=> !match_flag);
endmodule

// File: tb/tmr_ocmp_unit_bench.sv
module tmr_ocmp_unit_bench;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 0, cnt_wr = 0, cmp_wr = 0, mode_wr = 0, force_stb = 0, flag_clr = 0;
   logic dir = 0, port_val = 0;
   logic [W-1:0] cnt_wdata = '0, cmp_wdata = '0;
   logic [1:0] mode_wdata = 2'b00;
   logic [W-1:0] cnt_q, cmp_q;
   logic [1:0] mode_q;
   logic match_flag, oc_state, pin_out, pin_oe;

   always #4 clk = ~clk;

   tmr_ocmp_unit #(.CNT_W(W)) u_tmr_ocmp_unit (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
      .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
      .force_stb(force_stb), .flag_clr(flag_clr), .dir(dir), .port_val(port_val),
      .cnt_q(cnt_q), .cmp_q(cmp_q), .mode_q(mode_q), .match_flag(match_flag),
      .oc_state(oc_state), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   typedef struct {
      logic [W-1:0] cnt;
      logic [1:0]   mode;
      logic         flag;
      logic         oc;
      logic         pin;
      logic         oe;
      string        req;
   } exp_t;

   exp_t sb[$];
   int total = 0, bad = 0;
   bit done = 0;

   // reference state, kept from the requirements
   logic [W-1:0] m_cnt = '0, m_cmp = '0;
   logic [1:0]   m_mode = 2'b00;
   logic         m_flag = 0, m_oc = 0, m_blk = 0;

   task automatic chk(input string name, input int got, input int exp, input string req);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, name, got, exp);
      end
   endtask

   // monitor: compares at the falling edge
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         chk("cnt",  cnt_q,      e.cnt,  e.req);
         chk("mode", mode_q,     e.mode, e.req);
         chk("flag", match_flag, e.flag, e.req);
         chk("oc",   oc_state,   e.oc,   e.req);
         chk("pin",  pin_out,    e.pin,  e.req);
         chk("oe",   pin_oe,     e.oe,   e.req);
      end
   end

   task automatic push_exp(input string req);
      exp_t e;
      e.cnt = m_cnt; e.mode = m_mode; e.flag = m_flag; e.oc = m_oc;
      e.pin = (m_mode != 2'b00) ? m_oc : port_val;
      e.oe = dir; e.req = req;
      sb.push_back(e);
   endtask

   // driver: one cycle of stimulus, entered just after a falling edge
   task automatic op(input logic tk, input logic cw, input logic [W-1:0] cd,
                     input logic pw, input logic [W-1:0] pd,
                     input logic mw, input logic [1:0] md,
                     input logic fs, input logic fc, input string req);
      logic hit;
      tick = tk; cnt_wr = cw; cnt_wdata = cd; cmp_wr = pw; cmp_wdata = pd;
      mode_wr = mw; mode_wdata = md; force_stb = fs; flag_clr = fc;
      hit = tk && !cw && !m_blk && (m_cnt == m_cmp);
      @(posedge clk);
      #1;
      if (hit || fs) begin
         case (m_mode)
            2'b01: m_oc = !m_oc;
            2'b10: m_oc = 1'b0;
            2'b11: m_oc = 1'b1;
            default: ;
         endcase
      end
      if (hit) m_flag = 1'b1;
      else if (fc) m_flag = 1'b0;
      if (cw) m_blk = 1'b1;
      else if (tk) m_blk = 1'b0;
      if (cw) m_cnt = cd;
      else if (tk) m_cnt = m_cnt + 1'b1;
      if (pw) m_cmp = pd;
      if (mw) m_mode = md;
      tick = 0; cnt_wr = 0; cmp_wr = 0; mode_wr = 0; force_stb = 0; flag_clr = 0;
      push_exp(req);
      @(negedge clk);
      #1;
   endtask

   task automatic ticks(input int n, input string req);
      for (int i = 0; i < n; i++) op(1, 0, '0, 0, '0, 0, 2'b00, 0, 0, req);
   endtask
   task automatic idle(input int n, input string req);
      for (int i = 0; i < n; i++) op(0, 0, '0, 0, '0, 0, 2'b00, 0, 0, req);
   endtask
   task automatic set_cnt(input logic [W-1:0] v, input string req);
      op(0, 1, v, 0, '0, 0, 2'b00, 0, 0, req);
   endtask
   task automatic set_cmp(input logic [W-1:0] v, input string req);
      op(0, 0, '0, 1, v, 0, 2'b00, 0, 0, req);
   endtask
   task automatic set_mode(input logic [1:0] v, input string req);
      op(0, 0, '0, 0, '0, 1, v, 0, 0, req);
   endtask
   task automatic fire(input string req);
      op(0, 0, '0, 0, '0, 0, 2'b00, 1, 0, req);
   endtask
   task automatic clr(input string req);
      op(0, 0, '0, 0, '0, 0, 2'b00, 0, 1, req);
   endtask

   initial begin
      #400000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      push_exp("R1 reset state");
      @(negedge clk); #1;
      // R1 explicit: compare register also 0
      chk("cmp", cmp_q, 0, "R1");

      dir = 1; port_val = 1;
      idle(1, "R10 port drives pin in mode 00");
      set_cmp(8'd5, "R9 cmp write");
      set_mode(2'b11, "R9 mode set");
      ticks(5, "R2 count up");
      ticks(1, "R3 match sets flag and state");
      ticks(2, "R8 flag sticky");
      clr("R8 clear flag");
      // match and clear together: flag stays
      set_cnt(8'd3, "R6 write");
      ticks(2, "R7 approach");
      op(1, 0, '0, 0, '0, 0, 2'b00, 0, 1, "R8 set wins over clear");
      clr("R8 clear again");

      // toggle mode
      set_mode(2'b01, "R11 mode change keeps state");
      set_cnt(8'd4, "R6 write below cmp");
      ticks(2, "R4 toggle on match");
      clr("R8 clear");

      // write of compare value, idle gap, single blocked tick
      set_cnt(8'd5, "R6 write equal");
      idle(4, "R6 idle keeps block");
      ticks(1, "R6 blocked tick no match");
      set_cnt(8'd2, "R7 rewind");
      ticks(4, "R7 matching resumed");
      clr("R8 clear");

      // force under each mode
      set_mode(2'b10, "R9 clear mode");
      fire("R5 force clear no flag");
      set_mode(2'b11, "R9 set mode");
      fire("R5 force set no flag");
      set_mode(2'b01, "R9 toggle mode");
      fire("R5 force toggle");
      fire("R5 force toggle again");
      set_mode(2'b00, "R10 mode 00 port drives pin");
      fire("R4 force in mode 00 no change");
      port_val = 0;
      idle(1, "R10 port low");
      dir = 0;
      idle(1, "R10 oe follows dir");
      dir = 1;
      set_mode(2'b11, "R11 state retained");
      op(1, 0, '0, 0, '0, 1, 2'b10, 1, 0, "R9 new mode not yet used");
      fire("R9 new mode used");

      // wrap and write-vs-tick priority
      set_cnt(8'd254, "R2 near wrap");
      ticks(3, "R2 wrap");
      op(1, 1, 8'd40, 0, '0, 0, 2'b00, 0, 0, "R2 write wins over tick");
      ticks(2, "R2 after load");

      repeat (3) @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule